// File: doc/BRIEF.md
# Priority Spike Address Event Encoder

This block turns a vector of neuron spike flags into a stream of neuron addresses on an address-event bus. Each input bit stands for one neuron, and a 1 means that neuron fired in that cycle. The bus carries only one address per clock. When several neurons fire together, the block sends them one at a time, highest index first.

While a vector that still holds unserved spikes is being worked off, the block pulls its neuron-enable output low. This stalls the network so that the receiving neurons can take in each address. Any spike vectors that arrive during that time go into a small first-in first-out buffer. They are served in order of arrival once the current vector is empty. When nothing is pending, the bus shows an all-ones idle code that no neuron index can take.

Top module: `spike_aer_serializer`

## Requirements
- R1: With no spike pending and an all-zero input, the address output shows the idle code, all ones (7 for the default 5 neurons), one clock after that input is sampled.
- R2: A single-spike vector at index k, presented with nothing pending, shows k on the address output after the next rising edge. The neuron enable stays high.
- R3: A vector with several set bits is sent one address per clock, in descending index order, starting on the edge after it is accepted.
- R4: The neuron enable is low in exactly those cycles where unsent spikes remain after the address now on the bus. It goes high again together with the last address of the vector.
- R5: Nonzero vectors that arrive while a vector is being drained, or while the buffer holds entries, are stored. They are served in arrival order after the current vector is empty.
- R6: An all-zero input vector is never stored, so it never adds an idle cycle between buffered vectors.
- R7: When the buffer is full and is not being read in that cycle, a new nonzero vector is dropped and the overflow output goes high. The overflow output stays high until reset.
- R8: A synchronous active-high reset empties the buffer, discards the vector in progress, sets the address output to the idle code and the neuron enable to 1, and clears the overflow output.
- R9: The address width is ceil(log2(N+1)) for N neurons, so the idle code never equals a neuron index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spikes_i | input | N_NEURONS | Spike flags, bit k set when neuron k fires |
| aer_addr_o | output | ceil(log2(N_NEURONS+1)) | Registered address of the neuron being sent, or all ones when idle |
| neuron_en_o | output | 1 | Registered network enable; low while spikes of the current vector remain unsent |
| fifo_drop_o | output | 1 | Sticky flag, set when a vector is lost to a full buffer |

## Verification
Every result in this block is due on the first rising edge after the stimulus that causes it:
- the address of the chosen neuron;
- the enable level, computed from what is left of the vector;
- the overflow flag.

A buffered vector therefore shows its first address on the edge that follows the drain of the vector ahead of it. The bench drives each input at a falling edge and lets its queue-based model advance at the next rising edge. It compares all three outputs one nanosecond later. As a result, each comparison covers exactly one register stage, and every cycle of a drain is checked, not only its end.

// File: rtl/aer_pkg.sv
package aer_pkg;

  // Address width that leaves the all-ones code free for "idle" (R9)
  function automatic int addr_bits(input int n_neurons);
    return $clog2(n_neurons + 1);
  endfunction

endpackage

// File: rtl/spike_vec_fifo.sv
module spike_vec_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             drop_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             full, do_push, do_pop;

  assign full    = (count == FULLC);
  assign empty_o = (count == '0);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign dout_o  = mem[rd_ptr];

  // storage array without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      drop_o <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_i && full && !do_pop) drop_o <= 1'b1;
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) count <= FULLC);
  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop_i |-> !empty_o);
  // R8
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> empty_o);
endmodule

// File: rtl/msb_pick.sv
module msb_pick #(
  parameter int N  = 5,
  parameter int AW = 3
) (
  input  logic [N-1:0]  vec_i,
  output logic          hit_o,
  output logic [AW-1:0] idx_o,
  output logic [N-1:0]  rest_o
);
  logic [N-1:0] onehot;

  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    onehot = '0;
    // ascending scan: the last set bit seen is the highest one
    for (int i = 0; i < N; i++) begin
      if (vec_i[i]) begin
        hit_o  = 1'b1;
        idx_o  = AW'(i);
        onehot = '0;
        onehot[i] = 1'b1;
      end
    end
    rest_o = vec_i & ~onehot;
  end

  always_comb begin
    // R3
    if (hit_o) begin
      r3_clear_chk: assert ($countones(rest_o) + 1 == $countones(vec_i));
    end
  end
endmodule

// File: rtl/spike_aer_serializer.sv
module spike_aer_serializer
  import aer_pkg::*;
#(
  parameter int N_NEURONS  = 5,
  parameter int FIFO_DEPTH = 4,
  localparam int AW = addr_bits(N_NEURONS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_NEURONS-1:0] spikes_i,
  output logic [AW-1:0]        aer_addr_o,
  output logic                 neuron_en_o,
  output logic                 fifo_drop_o
);
  localparam logic [AW-1:0] IDLE = {AW{1'b1}};

  logic [N_NEURONS-1:0] rem_q, src, rest, fifo_head;
  logic                 busy, fifo_empty, push, pop, hit;
  logic [AW-1:0]        idx;

  assign busy = |rem_q;
  assign pop  = !busy && !fifo_empty;
  assign push = (|spikes_i) && (busy || !fifo_empty);

  // feedback mux: leftover bits, then buffered vectors, then live input
  always_comb begin
    if (busy)             src = rem_q;
    else if (!fifo_empty) src = fifo_head;
    else                  src = spikes_i;
  end

  spike_vec_fifo #(.WIDTH(N_NEURONS), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .din_i   (spikes_i),
    .pop_i   (pop),
    .dout_o  (fifo_head),
    .empty_o (fifo_empty),
    .drop_o  (fifo_drop_o)
  );

  msb_pick #(.N(N_NEURONS), .AW(AW)) u_pick (
    .vec_i  (src),
    .hit_o  (hit),
    .idx_o  (idx),
    .rest_o (rest)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q       <= '0;
      aer_addr_o  <= IDLE;
      neuron_en_o <= 1'b1;
    end else begin
      rem_q       <= rest;
      aer_addr_o  <= hit ? idx : IDLE;
      neuron_en_o <= (rest == '0);
    end
  end

  // R4
  stall_next_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !neuron_en_o |=> aer_addr_o != IDLE);
  // R3
  descending_chk: assert property (@(posedge clk) disable iff (rst)
    !neuron_en_o |=> aer_addr_o < $past(aer_addr_o));
  // R7
  sticky_drop_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_drop_o |=> fifo_drop_o);
endmodule

// File: tb/sim_spike_aer_serializer.sv
module sim_spike_aer_serializer;
  localparam int N     = 5;
  localparam int DEPTH = 4;
  localparam int AW    = $clog2(N + 1);      // R9
  localparam int IDLEV = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  spikes = '0;
  logic [AW-1:0] addr;
  logic          en, drop;

  always #2 clk = ~clk;   // 250 MHz

  spike_aer_serializer #(.N_NEURONS(N), .FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .spikes_i(spikes),
    .aer_addr_o(addr), .neuron_en_o(en), .fifo_drop_o(drop)
  );

  int vecs = 0;
  int bad  = 0;
  logic [N-1:0] q[$];
  logic [N-1:0] rem = '0;
  int  exp_addr = IDLEV;
  bit  exp_en = 1'b1;
  bit  exp_drop = 1'b0;

  task automatic model_edge(input logic [N-1:0] vin, input bit r);
    logic [N-1:0] src;
    bit took;
    int k;
    if (r) begin
      q.delete(); rem = '0; exp_addr = IDLEV; exp_en = 1'b1; exp_drop = 1'b0;
      return;
    end
    took = 1'b0;
    if (rem != 0) src = rem;
    else if (q.size() > 0) src = q.pop_front();
    else begin src = vin; took = 1'b1; end
    if (!took && vin != 0) begin
      if (q.size() < DEPTH) q.push_back(vin);
      else exp_drop = 1'b1;
    end
    k = -1;
    for (int i = 0; i < N; i++) if (src[i]) k = i;
    if (k >= 0) begin
      exp_addr = k;
      rem = src;
      rem[k] = 1'b0;
    end else begin
      exp_addr = IDLEV;
      rem = '0;
    end
    exp_en = (rem == 0);
  endtask

  task automatic compare(input string tag);
    vecs++;
    if (int'(addr) != exp_addr || en != exp_en || drop != exp_drop) begin
      bad++;
      $display("FAIL %s: addr=%0d en=%0b drop=%0b, expected addr=%0d en=%0b drop=%0b",
               tag, addr, en, drop, exp_addr, exp_en, exp_drop);
    end
  endtask

  task automatic step(input logic [N-1:0] v, input bit r, input string tag);
    @(negedge clk);
    spikes = v;
    rst = r;
    @(posedge clk);
    model_edge(v, r);
    #1;
    compare(tag);
  endtask

  task automatic drain(input int n, input string tag);
    for (int i = 0; i < n; i++) step('0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    step('0, 1'b1, "R8");
    step('0, 1'b1, "R8");
    step('0, 1'b0, "R1");        // idle code 7 with 3-bit bus (R9)
    step(5'b00001, 1'b0, "R2");
    step('0, 1'b0, "R1");
    step(5'b10000, 1'b0, "R2");
    step(5'b01001, 1'b0, "R3");
    step('0, 1'b0, "R4");
    drain(2, "R1");
    // four neurons together, two more firing during the drain
    step(5'b11011, 1'b0, "R3");
    step(5'b00110, 1'b0, "R5");
    drain(6, "R4");
    // zero vector during drain must not be stored
    step(5'b11000, 1'b0, "R3");
    step(5'b00000, 1'b0, "R6");
    step(5'b00001, 1'b0, "R6");
    drain(3, "R6");
    // flood the buffer to force a drop
    for (int i = 0; i < 9; i++) step(5'b11111, 1'b0, "R7");
    drain(40, "R7");
    // reset in the middle of a drain
    step(5'b11111, 1'b0, "R3");
    step(5'b10101, 1'b0, "R5");
    step('0, 1'b1, "R8");
    step('0, 1'b0, "R8");
    // sparse random traffic
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] v;
      v = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      step(v, 1'b0, "R5");
    end
    drain(40, "R5");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule